// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This block lets the cores of a small cluster (up to four by default) interrupt one another. Every core reaches it through one shared command port. A command carries the identity of the issuing core, an opcode, and a 2-bit argument that names either a target core or a sender core. For each target core the block keeps a vector of pending senders, and it drives one interrupt line per core. That line is high while its vector is not empty.

Software raises an interrupt toward another core with a generate command. It can first ask whether the target already has one pending, to avoid sending a redundant one. The interrupted core asks which cores signalled it and then acknowledges each sender separately. When several cores signal the same target, their requests merge into one asserted line, and the sender vector shows every one of them.

The command stream carries no back-pressure. The port accepts a command on every cycle that `cmd_valid` is high. Query results leave on a valid-only readback channel one cycle later, and the consumer must take each result in that cycle.

Top module: `ipi_unit`

## Requirements
- R1: After reset every sender vector is empty, every `irq_o` bit is low and `rb_valid` is low.
- R2: A generate command (opcode 1) from core s naming target t, with t different from s, sets sender bit s of target t. `irq_o[t]` is high from the next cycle.
- R3: A generate command whose target equals the issuing core changes no sender vector and no interrupt line.
- R4: A status command (opcode 0) naming target t gives `rb_valid` high on the next cycle. `rb_data` bit 0 then shows whether t had any sender pending when the command was taken, and all higher bits are zero.
- R5: A source command (opcode 2) gives `rb_valid` high on the next cycle. `rb_data` then holds the issuing core's sender vector, with bit s set when core s is pending, so a single sender s reads as 1 << s.
- R6: Generates from several senders toward the same target merge into one asserted `irq_o` line, and a later source command shows more than one bit set.
- R7: An acknowledge command (opcode 3) from core t naming index s clears only bit s of t's vector. Every other bit of every vector is left unchanged.
- R8: `irq_o[t]` stays high while any bit of t's vector is set. It drops in the cycle after the acknowledge that clears the last bit, and lines change only on cycles after an accepted command.
- R9: `rb_valid` is low on the cycle after any cycle that carries no status or source command. `rb_data` is zero while `rb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle (always accepted) |
| cmd_op | input | 2 | Opcode: 0 status, 1 generate, 2 source, 3 acknowledge |
| cmd_core | input | IDX_W | Identity of the issuing core |
| cmd_arg | input | IDX_W | Target core (status, generate) or sender index (acknowledge) |
| rb_valid | output | 1 | Readback result valid this cycle |
| rb_data | output | NUM_CORES | Readback result |
| irq_o | output | NUM_CORES | Interrupt line per core |

## Verification
The hardest situation to reach is a target whose sender vector holds several bits, then drains one acknowledge at a time while other targets stay busy. The bench sweeps every target against all sixteen sender subsets, including the target itself, which must be ignored. It checks the line and the readback after each generate and after each single acknowledge. A long pseudo-random command stream then mixes all opcodes, issuers and arguments across all rows against an arithmetic model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    OP_STATUS = 2'd0,
    OP_RAISE  = 2'd1,
    OP_SOURCE = 2'd2,
    OP_ACK    = 2'd3
  } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                               valid,
  input  logic [1:0]                         op,
  input  logic [IDX_W-1:0]                   core,
  input  logic [IDX_W-1:0]                   arg,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m,
  output logic [NUM_CORES-1:0][NUM_CORES-1:0] clr_m
);
  import ipi_pkg::*;

  // Row index = target core, column index = sender core.
  for (genvar t = 0; t < NUM_CORES; t++) begin : g_row
    for (genvar s = 0; s < NUM_CORES; s++) begin : g_col
      if (t == s) begin : g_diag
        assign set_m[t][s] = 1'b0;
      end else begin : g_off
        assign set_m[t][s] = valid && (op == OP_RAISE) &&
                             (arg == IDX_W'(t)) && (core == IDX_W'(s));
      end
      assign clr_m[t][s] = valid && (op == OP_ACK) &&
                           (core == IDX_W'(t)) && (arg == IDX_W'(s));
    end
  end
endmodule

// File: rtl/ipi_pend_row.sv
module ipi_pend_row #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] set_v,
  input  logic [NUM_CORES-1:0] clr_v,
  output logic [NUM_CORES-1:0] pend,
  output logic                 irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_v) | set_v;  // a raise outlives a clear
  end

  assign irq = |pend;
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               valid,
  input  logic [1:0]                         op,
  input  logic [IDX_W-1:0]                   core,
  input  logic [IDX_W-1:0]                   arg,
  input  logic [NUM_CORES-1:0][NUM_CORES-1:0] pend,
  output logic                               rb_valid,
  output logic [NUM_CORES-1:0]               rb_data
);
  import ipi_pkg::*;

  logic                 nxt_valid;
  logic [NUM_CORES-1:0] nxt_data;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_data  = '0;
    if (valid && op == OP_STATUS) begin
      nxt_valid   = 1'b1;
      nxt_data[0] = |pend[arg];
    end else if (valid && op == OP_SOURCE) begin
      nxt_valid = 1'b1;
      nxt_data  = pend[core];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else begin
      rb_valid <= nxt_valid;
      rb_data  <= nxt_data;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [IDX_W-1:0]     cmd_core,
  input  logic [IDX_W-1:0]     cmd_arg,
  output logic                 rb_valid,
  output logic [NUM_CORES-1:0] rb_data,
  output logic [NUM_CORES-1:0] irq_o
);
  logic [NUM_CORES-1:0][NUM_CORES-1:0] set_m, clr_m, pend;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .valid(cmd_valid), .op(cmd_op), .core(cmd_core), .arg(cmd_arg),
    .set_m(set_m), .clr_m(clr_m)
  );

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_tgt
    ipi_pend_row #(.NUM_CORES(NUM_CORES)) u_row (
      .clk(clk), .rst_n(rst_n),
      .set_v(set_m[t]), .clr_v(clr_m[t]),
      .pend(pend[t]), .irq(irq_o[t])
    );
  end

  ipi_readback #(.NUM_CORES(NUM_CORES)) u_rb (
    .clk(clk), .rst_n(rst_n),
    .valid(cmd_valid), .op(cmd_op), .core(cmd_core), .arg(cmd_arg),
    .pend(pend), .rb_valid(rb_valid), .rb_data(rb_data)
  );
endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_op,
  input logic [IDX_W-1:0]     cmd_core,
  input logic [IDX_W-1:0]     cmd_arg,
  input logic                 rb_valid,
  input logic [NUM_CORES-1:0] rb_data,
  input logic [NUM_CORES-1:0] irq_o
);
  // R2
  raise_sets_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_core != cmd_arg) |=> irq_o[$past(cmd_arg)]);

  // R3
  self_raise_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && cmd_core == cmd_arg) |=> $stable(irq_o));

  // R4
  status_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0) |=>
      (rb_valid && rb_data == NUM_CORES'($past(irq_o[cmd_arg]))));

  // R5
  source_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |=>
      (rb_valid && ((rb_data != '0) == $past(irq_o[cmd_core]))));

  // R8
  idle_lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(irq_o));

  // R9
  no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd2)) |=> (!rb_valid && rb_data == '0));
endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_core(cmd_core), .cmd_arg(cmd_arg), .rb_valid(rb_valid),
  .rb_data(rb_data), .irq_o(irq_o)
);

// File: tb/ipi_unit_tb.sv
module ipi_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [1:0]    cmd_core = '0;
  logic [1:0]    cmd_arg = '0;
  logic          rb_valid;
  logic [NC-1:0] rb_data;
  logic [NC-1:0] irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [NC-1:0] mdl [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_unit #(.NUM_CORES(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_core(cmd_core), .cmd_arg(cmd_arg), .rb_valid(rb_valid),
    .rb_data(rb_data), .irq_o(irq_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_lines();
    logic [NC-1:0] l;
    for (int t = 0; t < NC; t++) l[t] = |mdl[t];
    return l;
  endfunction

  // Drive at a falling edge, compare at the following falling edge.
  task automatic issue(input logic [1:0] op, input logic [1:0] core,
                       input logic [1:0] arg, input string tag);
    logic          e_v;
    logic [NC-1:0] e_d;
    e_v = (op == 2'd0) || (op == 2'd2);
    e_d = '0;
    if (op == 2'd0) e_d[0] = |mdl[arg];
    if (op == 2'd2) e_d = mdl[core];
    if (op == 2'd1 && core != arg) mdl[arg][core] = 1'b1;
    if (op == 2'd3) mdl[core][arg] = 1'b0;
    cmd_valid = 1'b1; cmd_op = op; cmd_core = core; cmd_arg = arg;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    check(e_v ? tag : "R9", "rb_valid", int'(rb_valid), int'(e_v));
    check(e_v ? tag : "R9", "rb_data", int'(rb_data), int'(e_d));
    check(op == 2'd3 ? "R8" : tag, "irq_o", int'(irq_o), int'(exp_lines()));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int t = 0; t < NC; t++) mdl[t] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "irq_o", int'(irq_o), 0);
    check("R1", "rb_valid", int'(rb_valid), 0);
    issue(2'd2, 2'd1, 2'd0, "R1");

    // Exhaustive: every target against every sender subset.
    for (int t = 0; t < NC; t++) begin
      for (int m = 0; m < 16; m++) begin
        for (int s = 0; s < NC; s++)
          if (m[s]) issue(2'd1, 2'(s), 2'(t), (s == t) ? "R3" : "R2");
        issue(2'd0, 2'((t + 1) % NC), 2'(t), "R4");
        issue(2'd2, 2'(t), 2'd0, ($countones(m & ~(1 << t)) > 1) ? "R6" : "R5");
        for (int s = 0; s < NC; s++)
          if (m[s]) issue(2'd3, 2'(t), 2'(s), "R7");
        check("R8", "drained", int'(irq_o[t]), 0);
      end
    end

    // Mixed pseudo-random stream across all rows.
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7]) issue(lfsr[1:0], lfsr[3:2], lfsr[5:4], "R7");
      else begin
        @(negedge clk);
        check("R8", "idle irq_o", int'(irq_o), int'(exp_lines()));
        check("R9", "idle rb_valid", int'(rb_valid), 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule